// File: doc/BRIEF.md
# Synchronous Mask ROM Command Sequencer

This block is the controller side of a synchronous mask ROM that speaks a cut-down SDRAM-style command set. The ROM sits on a multiplexed 13-bit address bus with four active-low chip selects and a 32-bit data bus. After reset the sequencer waits a fixed number of idle cycles. It then loads the ROM's mode register once, on all four chips at the same time. The mode word carries the CAS latency and a read-latency bit. After that it serves read requests. Each request becomes a row activate, at least one no-operation cycle, a read, a four-word data burst and a burst stop.

Read requests arrive on a valid/ready stream that carries a chip (bank) number and a 26-bit word address. The upper 13 bits are the row and the lower 13 bits are the column. `req_ready` is high only while the sequencer is idle. A requester holding `req_valid` high while `req_ready` is low must keep its bank and address stable, and the request is taken on the first edge where both are high. Returned words leave on `rd_valid`/`rd_data` with no back-pressure: the ROM burst cannot be paused, so the consumer must take each word in the cycle it is shown.

Two plain control inputs, `pd_enter` and `pd_exit`, move the ROM in and out of its low-power state by dropping and raising clock enable.

Top module: `smrom_seq`

## Requirements
- R1: During reset and until the mode register load, all chip selects, `mem_ras_n`, `mem_cas_n`, `mem_we_n` and `mem_oe_n` are high, `mem_cke` is high, and `req_ready` and `rd_valid` are low. Exactly one mode register load occurs, after INIT_CYCLES idle cycles following reset release.
- R2: The mode register load drives all four chip selects low and `mem_ras_n`, `mem_cas_n` and `mem_we_n` low, with `mem_oe_n` high. `mem_addr` carries the mode word: bits 12:7 are zero, bit 6 is RD_LAT, bits 5:3 are CAS_LAT and bits 2:0 are 3'b010.
- R3: `req_ready` is high only in the idle state, and a request transfers on an edge with `req_valid` and `req_ready` both high. The request selects chip `req_bank` (that chip's `mem_cs_n` bit is low, the others high), with row `req_addr[25:13]` and column `req_addr[12:0]`. At most one chip select is low, except during the mode register load.
- R4: A row activate appears in the cycle after the transfer. It drives the selected chip select low, `mem_ras_n` low, `mem_cas_n` high and `mem_we_n` high, with the row on `mem_addr` and `mem_cke` high.
- R5: The row activate is followed by ACT_GAP no-operation cycles (all chip selects high, all three strobes high). The read comes ACT_GAP+1 cycles after the activate.
- R6: The read drives the selected chip select low, `mem_ras_n` high, `mem_cas_n` low and `mem_we_n` high, with the column on `mem_addr`. `mem_oe_n` is low from the read cycle until the last word is captured.
- R7: Let E be the edge on which the read command is sampled. Word i (i = 0..3) is captured from `mem_dq` at edge E+CAS_LAT+i and shown on `rd_data` with `rd_valid` high in the following cycle. The words come in burst order and there is no gap between them.
- R8: In the cycle after the last capture a burst stop drives the selected chip select low, `mem_ras_n` high, `mem_cas_n` high and `mem_we_n` low, with `mem_oe_n` high. The next cycle is idle with `req_ready` high.
- R9: In idle with `pd_enter` high and no valid request, `mem_cke` falls from 1 to 0 in the next cycle, with all chip selects and strobes high. A valid request in the same cycle takes priority and `mem_cke` stays high.
- R10: While `mem_cke` is low, `req_ready` is low, `req_valid` is ignored and no command is issued.
- R11: `pd_exit` during power-down raises `mem_cke` from 0 to 1 in the next cycle, with all chip selects high for one no-operation cycle. After that cycle `req_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_bank | input | 2 | Chip number to read |
| req_addr | input | 26 | Row in bits 25:13, column in bits 12:0 |
| pd_enter | input | 1 | Request entry to low-power state |
| pd_exit | input | 1 | Request exit from low-power state |
| rd_valid | output | 1 | Returned word valid (no back-pressure) |
| rd_data | output | 32 | Returned word |
| mem_addr | output | 13 | Multiplexed row/column/mode address |
| mem_cs_n | output | 4 | Chip selects, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, used only as mode-load strobe |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_cke | output | 1 | Clock enable |
| mem_dq | input | 32 | Data from the ROM |

## Verification
Every result has a fixed position counted from its cause:
- The row activate is due in the cycle after the edge that takes the request, and the read comes ACT_GAP+1 cycles later.
- The first word appears CAS_LAT cycles after the edge that samples the read, and the burst stop appears in the same cycle as the last word.
- `mem_cke` moves in the cycle after `pd_enter` or `pd_exit`.

The bench keeps an edge counter and a ROM model that puts a word on `mem_dq` only for the exact edges where a capture is due, so a capture that is early or late picks up a poison value. A monitor that samples on the falling edge compares each command, each word and each cycle index against a value derived from the request that caused it.

// File: rtl/smrom_pkg.sv
package smrom_pkg;

  localparam int MODE_BITS = 13;

  typedef enum logic [3:0] {
    ST_INIT, ST_MRS, ST_IDLE, ST_ACT, ST_GAP,
    ST_READ, ST_BURST, ST_STOP, ST_PDN, ST_PDX
  } seq_state_t;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_ACT, CMD_READ, CMD_STOP
  } bus_cmd_t;

  // Fixed mode layout: zeros above bit 6, latency bit, CAS latency, burst code.
  function automatic logic [MODE_BITS-1:0] mode_word(input logic rl, input logic [2:0] cl);
    logic [MODE_BITS-1:0] w;
    w      = '0;
    w[6]   = rl;
    w[5:3] = cl;
    w[2:0] = 3'b010;
    return w;
  endfunction

endpackage

// File: rtl/smrom_fsm.sv
module smrom_fsm
  import smrom_pkg::*;
#(
  parameter int INIT_CYCLES = 8,
  parameter int ACT_GAP     = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     pd_enter,
  input  logic     pd_exit,
  input  logic     burst_done,
  output logic     req_ready,
  output logic     accept,
  output logic     read_issue,
  output logic     cke_o,
  output logic     rd_win,
  output bus_cmd_t cmd
);

  localparam int CMAX = (INIT_CYCLES > ACT_GAP) ? INIT_CYCLES : ACT_GAP;
  localparam int CW   = $clog2(CMAX + 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_INIT: begin
        if (cnt_q == CW'(INIT_CYCLES - 1)) begin
          state_d = ST_MRS;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_MRS:  state_d = ST_IDLE;
      ST_IDLE: begin
        if (req_valid)     state_d = ST_ACT;
        else if (pd_enter) state_d = ST_PDN;
      end
      ST_ACT: begin
        state_d = ST_GAP;
        cnt_d   = '0;
      end
      ST_GAP: begin
        if (cnt_q == CW'(ACT_GAP - 1)) begin
          state_d = ST_READ;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_READ:  state_d = ST_BURST;
      ST_BURST: if (burst_done) state_d = ST_STOP;
      ST_STOP:  state_d = ST_IDLE;
      ST_PDN:   if (pd_exit) state_d = ST_PDX;
      ST_PDX:   state_d = ST_IDLE;
      default:  state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign read_issue = (state_q == ST_READ);
  assign cke_o      = (state_q != ST_PDN);
  assign rd_win     = (state_q == ST_READ) || (state_q == ST_BURST);

  always_comb begin
    case (state_q)
      ST_MRS:  cmd = CMD_MRS;
      ST_ACT:  cmd = CMD_ACT;
      ST_READ: cmd = CMD_READ;
      ST_STOP: cmd = CMD_STOP;
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/smrom_burst.sv
module smrom_burst #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              last
);

  localparam int LAST_IDX = CAS_LAT + BURST_LEN - 1;
  localparam int CW       = $clog2(LAST_IDX + 2);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          take;

  // cnt_q holds the number of edges since the read was sampled
  assign take = active_q && (cnt_q >= CW'(CAS_LAT));
  assign last = take && (cnt_q == CW'(LAST_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= CW'(1);
      end else if (active_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (last) active_q <= 1'b0;
      end
      rd_valid <= take;
      if (take) rd_data <= dq;
    end
  end

endmodule

// File: rtl/smrom_cmd_enc.sv
module smrom_cmd_enc
  import smrom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NCS    = 4,
  localparam int BW    = $clog2(NCS)
) (
  input  bus_cmd_t          cmd,
  input  logic [BW-1:0]     bank,
  input  logic [ADDR_W-1:0] row,
  input  logic [ADDR_W-1:0] col,
  input  logic [ADDR_W-1:0] mode,
  output logic [NCS-1:0]    cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);

  logic [NCS-1:0] sel;

  for (genvar g = 0; g < NCS; g++) begin : g_sel
    assign sel[g] = (bank == BW'(g));
  end

  always_comb begin
    cs_n  = '1;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    case (cmd)
      CMD_MRS: begin
        cs_n  = '0;
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        addr  = mode;
      end
      CMD_ACT: begin
        cs_n  = ~sel;
        ras_n = 1'b0;
        addr  = row;
      end
      CMD_READ: begin
        cs_n  = ~sel;
        cas_n = 1'b0;
        addr  = col;
      end
      CMD_STOP: begin
        cs_n = ~sel;
        we_n = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/smrom_seq.sv
module smrom_seq
  import smrom_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 32,
  parameter int NCS         = 4,
  parameter int BURST_LEN   = 4,
  parameter int CAS_LAT     = 2,
  parameter bit RD_LAT      = 1'b0,
  parameter int INIT_CYCLES = 8,
  parameter int ACT_GAP     = 1,
  localparam int BANK_W     = $clog2(NCS),
  localparam int REQ_W      = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [REQ_W-1:0]  req_addr,
  input  logic              pd_enter,
  input  logic              pd_exit,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_cke,
  input  logic [DATA_W-1:0] mem_dq
);

  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(mode_word(RD_LAT, 3'(CAS_LAT)));

  logic              accept, read_issue, burst_last, rd_win;
  bus_cmd_t          cmd;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] row_q, col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (accept) begin
      bank_q <= req_bank;
      row_q  <= req_addr[REQ_W-1:ADDR_W];
      col_q  <= req_addr[ADDR_W-1:0];
    end
  end

  smrom_fsm #(
    .INIT_CYCLES(INIT_CYCLES),
    .ACT_GAP    (ACT_GAP)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pd_enter  (pd_enter),
    .pd_exit   (pd_exit),
    .burst_done(burst_last),
    .req_ready (req_ready),
    .accept    (accept),
    .read_issue(read_issue),
    .cke_o     (mem_cke),
    .rd_win    (rd_win),
    .cmd       (cmd)
  );

  smrom_burst #(
    .DATA_W   (DATA_W),
    .BURST_LEN(BURST_LEN),
    .CAS_LAT  (CAS_LAT)
  ) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (read_issue),
    .dq      (mem_dq),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .last    (burst_last)
  );

  smrom_cmd_enc #(
    .ADDR_W(ADDR_W),
    .NCS   (NCS)
  ) u_enc (
    .cmd  (cmd),
    .bank (bank_q),
    .row  (row_q),
    .col  (col_q),
    .mode (MODE_ADDR),
    .cs_n (mem_cs_n),
    .ras_n(mem_ras_n),
    .cas_n(mem_cas_n),
    .we_n (mem_we_n),
    .addr (mem_addr)
  );

  assign mem_oe_n = ~rd_win;

endmodule

// File: rtl/smrom_seq_chk.sv
module smrom_seq_chk #(
  parameter int ADDR_W  = 13,
  parameter int NCS     = 4,
  parameter int CAS_LAT = 2,
  parameter bit RD_LAT  = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NCS-1:0]    mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_cke
);

  localparam logic [ADDR_W-1:0] MODE = ADDR_W'(smrom_pkg::mode_word(RD_LAT, 3'(CAS_LAT)));

  logic one_sel, is_mrs, is_act, is_rd, quiet;
  assign one_sel = ($countones(~mem_cs_n) == 1);
  assign is_mrs  = (mem_cs_n == '0) && !mem_ras_n && !mem_cas_n && !mem_we_n;
  assign is_act  = one_sel && !mem_ras_n && mem_cas_n && mem_we_n;
  assign is_rd   = one_sel && mem_ras_n && !mem_cas_n && mem_we_n;
  assign quiet   = (mem_cs_n == '1) && mem_ras_n && mem_cas_n && mem_we_n;

  // R2
  mrs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (mem_oe_n && mem_addr == MODE));

  // R3
  cs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '0) |-> ($countones(~mem_cs_n) <= 1));

  // R5
  act_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> quiet);

  // R6
  read_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> !mem_oe_n);

  // R7
  rdv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));

  // R9
  pdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> quiet);

  // R10
  pdn_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> !req_ready);

  // R11
  pdx_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> (quiet && !req_ready));

endmodule

bind smrom_seq smrom_seq_chk #(
  .ADDR_W (ADDR_W),
  .NCS    (NCS),
  .CAS_LAT(CAS_LAT),
  .RD_LAT (RD_LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rd_valid (rd_valid),
  .mem_addr (mem_addr),
  .mem_cs_n (mem_cs_n),
  .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_cke  (mem_cke)
);

// File: tb/smrom_seq_bench.sv
module smrom_seq_bench;

  localparam int CL   = 2;
  localparam int BL   = 4;
  localparam int INIT = 8;
  localparam int GAP  = 1;
  localparam logic [12:0] MODE_EXP = 13'h012; // zeros, RL=0, CL=010, 010

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_bank = '0;
  logic [25:0] req_addr = '0;
  logic        pd_enter = 1'b0, pd_exit = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [12:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_cke;
  logic [31:0] mem_dq = 32'hBAD0_0BAD;

  always #2 clk = ~clk;

  smrom_seq #(
    .ADDR_W(13), .DATA_W(32), .NCS(4), .BURST_LEN(BL), .CAS_LAT(CL),
    .RD_LAT(1'b0), .INIT_CYCLES(INIT), .ACT_GAP(GAP)
  ) u_smrom_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_addr(req_addr), .pd_enter(pd_enter), .pd_exit(pd_exit),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_cke(mem_cke), .mem_dq(mem_dq)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  int hs_cyc = -1, act_cyc = -1, e_edge = -1, word_k = 0, mrs_cnt = 0, act_cnt = 0;
  logic [1:0]  exp_bank, cur_bank;
  logic [12:0] exp_row, exp_col, cur_row, cur_col;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] pat(input logic [1:0] b, input logic [12:0] r, input logic [12:0] c);
    return {b, r, c, 4'h5};
  endfunction

  function automatic logic [12:0] wcol(input logic [12:0] c, input int i);
    return {c[12:2], c[1:0] + 2'(i)};
  endfunction

  function automatic logic [1:0] dec(input logic [3:0] cs);
    case (cs)
      4'b1110: return 2'd0;
      4'b1101: return 2'd1;
      4'b1011: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  wire sel1   = (mem_cs_n == 4'b1110) || (mem_cs_n == 4'b1101) ||
                (mem_cs_n == 4'b1011) || (mem_cs_n == 4'b0111);
  wire b_mrs  = (mem_cs_n == 4'h0) && !mem_ras_n && !mem_cas_n && !mem_we_n;
  wire b_act  = sel1 && !mem_ras_n && mem_cas_n && mem_we_n;
  wire b_rd   = sel1 && mem_ras_n && !mem_cas_n && mem_we_n;
  wire b_stop = sel1 && mem_ras_n && mem_cas_n && !mem_we_n;
  wire b_nop  = (mem_cs_n == 4'hF) && mem_ras_n && mem_cas_n && mem_we_n;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Monitor, scoreboard and ROM model, all on the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (b_mrs) begin
        mrs_cnt++;
        chk(cyc == INIT, "R1 mode load cycle", cyc, INIT);
        chk(mem_addr == MODE_EXP && mem_oe_n, "R2 mode word", {mem_oe_n, mem_addr}, {1'b1, MODE_EXP});
      end
      if (b_act) begin
        act_cnt++;
        act_cyc  = cyc;
        cur_bank = dec(mem_cs_n);
        cur_row  = mem_addr;
        chk(cyc == hs_cyc, "R4 activate cycle", cyc, hs_cyc);
        chk({cur_bank, cur_row, mem_cke} == {exp_bank, exp_row, 1'b1}, "R4/R3 activate bank,row,cke",
            {cur_bank, cur_row, mem_cke}, {exp_bank, exp_row, 1'b1});
      end
      if (act_cyc >= 0 && cyc == act_cyc + 1)
        chk(b_nop, "R5 nop after activate", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 7'h7F);
      if (b_rd) begin
        chk(cyc == act_cyc + 1 + GAP, "R5 read cycle", cyc, act_cyc + 1 + GAP);
        chk({dec(mem_cs_n), mem_addr, mem_oe_n} == {exp_bank, exp_col, 1'b0}, "R6 read bank,col,oe",
            {dec(mem_cs_n), mem_addr, mem_oe_n}, {exp_bank, exp_col, 1'b0});
        cur_col = mem_addr;
        e_edge  = cyc + 1;
        word_k  = 0;
      end
      if (b_stop) begin
        chk(cyc == e_edge + CL + BL - 1, "R8 stop cycle", cyc, e_edge + CL + BL - 1);
        chk(dec(mem_cs_n) == cur_bank && mem_oe_n, "R8 stop chip,oe", {dec(mem_cs_n), mem_oe_n}, {cur_bank, 1'b1});
      end
      if (e_edge >= 0 && cyc == e_edge + CL + BL)
        chk(req_ready && b_nop, "R8 idle after stop", {req_ready, b_nop}, 2'b11);
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected word", rd_data, 0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R7 word data", rd_data, e);
          chk(cyc == e_edge + CL + word_k, "R7 word cycle", cyc, e_edge + CL + word_k);
          word_k++;
        end
      end
      begin
        int x;
        x = cyc + 1 - e_edge - CL;
        if (e_edge >= 0 && x >= 0 && x < BL) mem_dq = pat(cur_bank, cur_row, wcol(cur_col, x));
        else                                 mem_dq = 32'hBAD0_0BAD;
      end
    end
  end

  task automatic do_read(input logic [1:0] b, input logic [12:0] r, input logic [12:0] c);
    req_valid = 1'b1;
    req_bank  = b;
    req_addr  = {r, c};
    while (!req_ready) @(negedge clk);
    hs_cyc   = cyc + 1;
    exp_bank = b;
    exp_row  = r;
    exp_col  = c;
    for (int i = 0; i < BL; i++) exp_q.push_back(pat(b, r, wcol(c, i)));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n == 4'hF && mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n && mem_cke,
        "R1 bus idle in reset", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_cke}, 9'h1FF);
    chk(!req_ready && !rd_valid, "R1 ready/valid low in reset", {req_ready, rd_valid}, 2'b00);
    rst_n = 1'b1;
    wait_ready();
    chk(mrs_cnt == 1, "R1 single mode load", mrs_cnt, 1);

    do_read(2'd0, 13'h0123, 13'h0004);
    chk(!req_ready, "R3 ready low while busy", req_ready, 0);
    do_read(2'd3, 13'h1FFF, 13'h1FFE);   // held valid waits for ready
    do_read(2'd1, 13'h0A5A, 13'h0002);
    wait_ready();

    // R9 enter power-down
    pd_enter = 1'b1;
    @(negedge clk);
    pd_enter = 1'b0;
    chk(!mem_cke && b_nop && !req_ready, "R9 power-down entry", {mem_cke, b_nop, req_ready}, 3'b010);
    begin
      int acts;
      acts      = act_cnt;
      req_valid = 1'b1;
      req_bank  = 2'd2;
      req_addr  = 26'h155_5555;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(!req_ready && !mem_cke, "R10 request refused in power-down", {req_ready, mem_cke}, 2'b00);
      end
      req_valid = 1'b0;
      chk(act_cnt == acts, "R10 no command in power-down", act_cnt, acts);
    end
    pd_exit = 1'b1;
    @(negedge clk);
    pd_exit = 1'b0;
    chk(mem_cke && b_nop && !req_ready, "R11 exit cycle", {mem_cke, b_nop, req_ready}, 3'b110);
    @(negedge clk);
    chk(req_ready, "R11 ready after exit", req_ready, 1);

    // R9 priority: request beats pd_enter
    pd_enter = 1'b1;
    do_read(2'd2, 13'h0777, 13'h1003);
    pd_enter = 1'b0;
    chk(mem_cke, "R9 request wins over pd_enter", mem_cke, 1);
    wait_ready();
    do_read(2'd1, 13'h0000, 13'h0000);
    wait_ready();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);
    chk(mrs_cnt == 1, "R1 no further mode load", mrs_cnt, 1);
    finish_up();
  end

endmodule